// File: doc/BRIEF.md
# Input-Adaptive Split Approximate Adder

This block adds two 16-bit unsigned operands approximately, trading accuracy in the low bits for a short carry path. The operand width is divided into eight blocks of two bits each. The upper part is summed exactly with a ripple of full-adder cells. The lower part uses a carry-free speed adder that never passes a carry upward. The block is purely combinational.

The split between the exact and approximate parts is chosen for every addition by a selector that looks at the operand magnitudes. If either operand has any bit set in its three highest blocks, the operands count as large. In that case only those three blocks are exact and the lower five blocks are approximate. Otherwise the operands count as small: the six highest blocks are exact and only the two lowest blocks are approximate. A mode output reports which split was applied.

Top module: `aadd_split_top`

## Requirements
- R1: `wide_split_o` is 1 when any of bits 15..10 of `a_i` or `b_i` is 1, and 0 otherwise.
- R2: When `wide_split_o` is 1, `sum_o[16:10]` equals `a_i[15:10] + b_i[15:10]` exactly, with no carry coming in from bits 9..0.
- R3: When `wide_split_o` is 1, `sum_o[9:0]` is the carry-free result (R6) over operand bits 9..0.
- R4: When `wide_split_o` is 0, `sum_o[16:4]` equals `a_i[15:4] + b_i[15:4]` exactly, with no carry coming in from bits 3..0.
- R5: When `wide_split_o` is 0, `sum_o[3:0]` is the carry-free result (R6) over operand bits 3..0.
- R6: Carry-free rule over a field: scanning from the field's top bit downward, each result bit is the XOR of the operand bits until the highest position where both operand bits are 1. That position and every bit below it are 1. If no position has both bits at 1, the field result is the plain XOR.
- R7: The block has no storage. `sum_o` and `wide_split_o` reflect the current operands within the same clock period.
- R8: When `wide_split_o` is 0, `sum_o[16:11]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand, unsigned |
| b_i | input | 16 | Second operand, unsigned |
| sum_o | output | 17 | Approximate sum; bit 16 is the carry-out of the exact part |
| wide_split_o | output | 1 | 1 = three exact blocks (large operands), 0 = six exact blocks |

## Verification
Both results depend only on the current operands. The bench therefore expects them in the same clock period as the stimulus. It changes the operands just after a rising edge and compares `sum_o` and `wide_split_o` with its reference model at the following falling edge, so logic settling never lands on a sampling point. Directed pairs cover the border between the two modes, overflow into bit 16, and low fields with and without a position where both bits are 1. Pseudo-random pairs masked to small and large magnitudes then exercise both splits on every clock.

// File: rtl/aadd_pkg.sv
package aadd_pkg;

  // Split selection reported on the mode output
  typedef enum logic {
    SPLIT_NARROW = 1'b0,  // small operands: many exact blocks
    SPLIT_WIDE   = 1'b1   // large operands: few exact blocks
  } split_e;

  // One full-adder cell: {carry, sum}
  function automatic logic [1:0] fa_cell(input logic x, input logic y, input logic c);
    fa_cell = {(x & y) | (c & (x ^ y)), x ^ y ^ c};
  endfunction

endpackage

// File: rtl/aadd_selector.sv
module aadd_selector #(
  parameter int W     = 16,
  parameter int TOP_W = 6
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output aadd_pkg::split_e split_o
);
  logic top_active;

  assign top_active = (|a_i[W-1 -: TOP_W]) | (|b_i[W-1 -: TOP_W]);
  assign split_o    = top_active ? aadd_pkg::SPLIT_WIDE : aadd_pkg::SPLIT_NARROW;
endmodule

// File: rtl/aadd_speed_seg.sv
module aadd_speed_seg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  // Top-down scan: XOR until both bits are 1, then saturate to ones
  function automatic logic [W-1:0] carry_free(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r;
    logic         sat;
    sat = 1'b0;
    r   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (x[i] & y[i]) sat = 1'b1;
      r[i] = sat | (x[i] ^ y[i]);
    end
    return r;
  endfunction

  assign s_o = carry_free(a_i, b_i);
endmodule

// File: rtl/aadd_exact_seg.sv
module aadd_exact_seg #(
  parameter int W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] s_o,
  output logic         cout_o
);
  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar g = 0; g < W; g++) begin : g_cell
    logic [1:0] cs;
    assign cs         = aadd_pkg::fa_cell(a_i[g], b_i[g], chain[g]);
    assign s_o[g]     = cs[0];
    assign chain[g+1] = cs[1];
  end

  assign cout_o = chain[W];
endmodule

// File: rtl/aadd_split_top.sv
module aadd_split_top #(
  parameter int BLK_W          = 2,
  parameter int N_BLK          = 8,
  parameter int WIDE_ACC_BLK   = 3,
  parameter int NARROW_ACC_BLK = 6
) (
  input  logic [BLK_W*N_BLK-1:0] a_i,
  input  logic [BLK_W*N_BLK-1:0] b_i,
  output logic [BLK_W*N_BLK:0]   sum_o,
  output logic                   wide_split_o
);
  localparam int W         = BLK_W * N_BLK;
  localparam int WIDE_LO   = (N_BLK - WIDE_ACC_BLK) * BLK_W;
  localparam int NARROW_LO = (N_BLK - NARROW_ACC_BLK) * BLK_W;
  localparam int TOP_W     = W - WIDE_LO;
  localparam int MID_W     = WIDE_LO - NARROW_LO;

  aadd_pkg::split_e split;

  // Named internal events, brought out for the checker
  logic [WIDE_LO-1:0]   lo_wide_s;
  logic [NARROW_LO-1:0] lo_narrow_s;
  logic [MID_W-1:0]     mid_s;
  logic                 mid_cout;
  logic                 top_cin;
  logic [TOP_W-1:0]     top_s;
  logic                 top_cout;

  aadd_selector #(.W(W), .TOP_W(TOP_W)) u_sel (
    .a_i(a_i), .b_i(b_i), .split_o(split)
  );

  aadd_speed_seg #(.W(WIDE_LO)) u_spd_wide (
    .a_i(a_i[WIDE_LO-1:0]), .b_i(b_i[WIDE_LO-1:0]), .s_o(lo_wide_s)
  );

  aadd_speed_seg #(.W(NARROW_LO)) u_spd_narrow (
    .a_i(a_i[NARROW_LO-1:0]), .b_i(b_i[NARROW_LO-1:0]), .s_o(lo_narrow_s)
  );

  aadd_exact_seg #(.W(MID_W)) u_mid (
    .a_i(a_i[WIDE_LO-1:NARROW_LO]), .b_i(b_i[WIDE_LO-1:NARROW_LO]),
    .cin_i(1'b0), .s_o(mid_s), .cout_o(mid_cout)
  );

  // Middle blocks join the exact chain only in the narrow split
  assign top_cin = (split == aadd_pkg::SPLIT_NARROW) ? mid_cout : 1'b0;

  aadd_exact_seg #(.W(TOP_W)) u_top (
    .a_i(a_i[W-1:WIDE_LO]), .b_i(b_i[W-1:WIDE_LO]),
    .cin_i(top_cin), .s_o(top_s), .cout_o(top_cout)
  );

  always_comb begin
    if (split == aadd_pkg::SPLIT_WIDE) sum_o = {top_cout, top_s, lo_wide_s};
    else                               sum_o = {top_cout, top_s, mid_s, lo_narrow_s};
  end

  assign wide_split_o = (split == aadd_pkg::SPLIT_WIDE);
endmodule

// File: rtl/aadd_split_chk.sv
module aadd_split_chk #(
  parameter int W         = 16,
  parameter int WIDE_LO   = 10,
  parameter int NARROW_LO = 4
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W:0]   sum_o,
  input logic         wide_split_o,
  input logic         top_cin
);
  logic [W-WIDE_LO:0]   exp_wide_hi;
  logic [W-NARROW_LO:0] exp_narrow_hi;
  logic [W-1:0]         xr;

  assign exp_wide_hi   = {1'b0, a_i[W-1:WIDE_LO]} + {1'b0, b_i[W-1:WIDE_LO]};
  assign exp_narrow_hi = {1'b0, a_i[W-1:NARROW_LO]} + {1'b0, b_i[W-1:NARROW_LO]};
  assign xr            = a_i ^ b_i;

  always_comb begin
    if (wide_split_o) begin
      // R2: exact upper part, nothing enters from below
      a_r2_wide_upper_exact: assert (sum_o[W:WIDE_LO] == exp_wide_hi && !top_cin);
      // R3: every XOR one survives in the carry-free field
      a_r3_wide_low_covers_xor: assert ((sum_o[WIDE_LO-1:0] & xr[WIDE_LO-1:0]) == xr[WIDE_LO-1:0]);
    end else begin
      // R4: exact upper part over the six high blocks
      a_r4_narrow_upper_exact: assert (sum_o[W:NARROW_LO] == exp_narrow_hi);
      // R5: carry-free low field keeps every XOR one
      a_r5_narrow_low_covers_xor: assert ((sum_o[NARROW_LO-1:0] & xr[NARROW_LO-1:0]) == xr[NARROW_LO-1:0]);
      // R8: small operands cannot reach the top bits
      a_r8_narrow_top_clear: assert (sum_o[W:WIDE_LO+1] == '0);
    end
  end
endmodule

bind aadd_split_top aadd_split_chk #(
  .W(W), .WIDE_LO(WIDE_LO), .NARROW_LO(NARROW_LO)
) u_chk (
  .a_i(a_i), .b_i(b_i), .sum_o(sum_o),
  .wide_split_o(wide_split_o), .top_cin(top_cin)
);

// File: tb/aadd_split_top_test.sv
module aadd_split_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [16:0] sum;
  logic        mode;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  aadd_split_top uut (.a_i(a), .b_i(b), .sum_o(sum), .wide_split_o(mode));

  // Behavioural reference built from the requirements
  function automatic void model(input int x, input int y, output int m, output int s);
    int lo_n, hi, lo;
    bit sat;
    m    = (((x >> 10) | (y >> 10)) != 0) ? 1 : 0;  // R1
    lo_n = m ? 10 : 4;
    hi   = (x >> lo_n) + (y >> lo_n);               // R2 / R4
    lo   = 0;
    sat  = 0;
    for (int i = lo_n - 1; i >= 0; i--) begin       // R6
      if (((x >> i) & 1) == 1 && ((y >> i) & 1) == 1) sat = 1;
      if (sat || ((((x ^ y) >> i) & 1) == 1)) lo = lo | (1 << i);
    end
    s = (hi << lo_n) | lo;
  endfunction

  task automatic compare();
    int m, s, lo_n;
    model(int'(a), int'(b), m, s);
    lo_n = m ? 10 : 4;
    checks++;
    if (int'(mode) != m) begin
      errors++;
      $display("FAIL R1 a=%h b=%h mode actual=%0d expected=%0d", a, b, mode, m);
    end
    checks++;
    if (int'(sum) != s) begin
      errors++;
      if ((int'(sum) >> lo_n) != (s >> lo_n))
        $display("FAIL %s a=%h b=%h sum actual=%h expected=%h",
                 m ? "R2" : "R4 R8", a, b, sum, s[16:0]);
      else
        $display("FAIL %s R6 a=%h b=%h sum actual=%h expected=%h",
                 m ? "R3" : "R5", a, b, sum, s[16:0]);
    end
  endtask

  initial begin
    logic [15:0] qa[$];
    logic [15:0] qb[$];
    // Directed pairs: mode border, overflow, saturation cases
    qa.push_back(16'h000F); qb.push_back(16'h000F);
    qa.push_back(16'h0005); qb.push_back(16'h000A);
    qa.push_back(16'h03FF); qb.push_back(16'h03FF);
    qa.push_back(16'h03FF); qb.push_back(16'h0001);
    qa.push_back(16'h0300); qb.push_back(16'h0100);
    qa.push_back(16'h0400); qb.push_back(16'h0000);
    qa.push_back(16'h0000); qb.push_back(16'h0400);
    qa.push_back(16'h8000); qb.push_back(16'h8000);
    qa.push_back(16'hFFFF); qb.push_back(16'hFFFF);
    qa.push_back(16'hB39A); qb.push_back(16'h6913);
    qa.push_back(16'h0A00); qb.push_back(16'h0155);
    qa.push_back(16'h0200); qb.push_back(16'h0200);
    for (int k = 0; k < 400; k++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (k % 2 == 0) begin ra = ra & 16'h03FF; rb = rb & 16'h03FF; end
      qa.push_back(ra); qb.push_back(rb);
    end

    // Reset phase: zero operands must give zero sum in narrow mode
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (sum != '0 || mode != 1'b0) begin
      errors++;
      $display("FAIL R1 R4 reset sum=%h mode=%0d expected sum=0 mode=0", sum, mode);
    end
    rst = 1'b0;

    // R7: drive just after a rising edge, expect the result at the next falling edge
    while (qa.size() > 0) begin
      @(posedge clk);
      #1;
      a = qa.pop_front();
      b = qb.pop_front();
      @(negedge clk);
      compare();
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule